// File: doc/BRIEF.md
# Bus-Attached Countdown Watchdog

This block is a watchdog timer that sits on an APB slave port. Software writes a start count. Once counting is switched on, the block subtracts one from the count on every bus-clock cycle in which a separate tick-enable input is high. When the count lands on zero, the block latches a raw interrupt flag.

The counter rests at zero for one tick and reloads itself from the start count on the following tick, then keeps going. The raw flag stays set until software clears it. Writing anything to the clear register lowers the flag and refills the counter at once, so the clear register also serves as the watchdog's service ("kick") operation.

The tick-enable comes from outside the block. Its spacing can change while the counter runs without disturbing the remaining count. A lock register guards the writable registers against stray writes.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the start count, the current count, the enable bit, the raw flag and the lock state are all 0, and `irqOut` is low.
- R2: The slave never inserts wait states (`pready` is always 1). A write takes effect on a cycle with `psel`, `penable` and `pwrite` high. The register offsets are:
  - 0x000 start count
  - 0x004 current count (read-only)
  - 0x008 control, with bit 0 as the enable
  - 0x00C clear (write-only, reads 0)
  - 0x010 raw flag in bit 0
  - 0x014 masked flag in bit 0
  - 0xC00 lock

  Reads of any other offset return 0, and writes to them change nothing.
- R3: A write to the start count also copies the written value into the current count on the same edge.
- R4: While control bit 0 is 1, the current count drops by exactly one on each cycle where `tickEn` is high. It does not change on cycles where `tickEn` is low, nor at any time while control bit 0 is 0.
- R5: The tick that moves the current count from 1 to 0 sets the raw flag on that same edge.
- R6: The current count stays at 0 until the next tick. That tick reloads it from the start count, and counting carries on from there. The raw flag stays set through the reload.
- R7: A write of any data to the clear register lowers the raw flag and reloads the current count from the start count.
- R8: The masked flag equals the raw flag AND control bit 0, and `irqOut` follows the masked flag.
- R9: Writing 0x1ACCE551 to the lock register unlocks the block, and writing any other value locks it. While locked, writes to the start count, control and clear registers are ignored. Reading the lock register returns 1 in bit 0 when the block is locked.
- R10: The count depends only on the number of ticks, not on their spacing. Changing the gap between ticks in mid-count loses no part of the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| tickEn | input | 1 | Counting-clock enable, one tick per high cycle |
| irqOut | output | 1 | Masked watchdog interrupt |

## Verification
The count-step, zero-hold and flag-setting properties assume that no bus write lands on the same edge as the tick they describe. They therefore exclude such cycles in their antecedents rather than guessing which action wins. The stimulus holds `tickEn` low throughout every bus access and raises it only between transfers. Every observed count is therefore the result of plain ticks alone. Tick trains are driven both back to back and with gaps, so the spacing-independence property sees both patterns.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFF_START = 'h000;
  localparam int OFF_COUNT = 'h004;
  localparam int OFF_CTRL  = 'h008;
  localparam int OFF_CLEAR = 'h00C;
  localparam int OFF_RAW   = 'h010;
  localparam int OFF_MASK  = 'h014;
  localparam int OFF_LOCK  = 'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic loadWr;
    logic clrWr;
    logic countOn;
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStrobe_t      strobe,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tickEn,
  output logic [CNT_W-1:0] startQ,
  output logic [CNT_W-1:0] cntQ,
  output logic             risQ
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic stepNow;
  logic hitZero;

  assign stepNow = strobe.countOn && tickEn;
  assign hitZero = stepNow && (cntQ == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      cntQ   <= '0;
    end else if (strobe.loadWr) begin
      startQ <= wdata;
      cntQ   <= wdata;
    end else if (strobe.clrWr) begin
      cntQ <= startQ;
    end else if (stepNow) begin
      if (cntQ == '0) cntQ <= startQ;
      else            cntQ <= cntQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           risQ <= 1'b0;
    else if (strobe.clrWr)               risQ <= 1'b0;
    else if (hitZero && !strobe.loadWr)  risQ <= 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] startQ,
  input  logic [DATA_W-1:0] cntQ,
  input  logic              risQ,
  output wdogStrobe_t       strobe,
  output logic [DATA_W-1:0] prdata,
  output logic              enQ,
  output logic              lockedQ,
  output logic              misOut
);
  logic wrCyc;
  logic wrOpen;
  logic hitStart, hitCount, hitCtrl, hitClear, hitRaw, hitMask, hitLock;

  assign hitStart = paddr == ADDR_W'(OFF_START);
  assign hitCount = paddr == ADDR_W'(OFF_COUNT);
  assign hitCtrl  = paddr == ADDR_W'(OFF_CTRL);
  assign hitClear = paddr == ADDR_W'(OFF_CLEAR);
  assign hitRaw   = paddr == ADDR_W'(OFF_RAW);
  assign hitMask  = paddr == ADDR_W'(OFF_MASK);
  assign hitLock  = paddr == ADDR_W'(OFF_LOCK);

  assign wrCyc  = psel && penable && pwrite;
  assign wrOpen = wrCyc && !lockedQ;

  assign strobe.loadWr  = wrOpen && hitStart;
  assign strobe.clrWr   = wrOpen && hitClear;
  assign strobe.countOn = enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= 1'b0;
    else if (wrOpen && hitCtrl) enQ <= pwdata[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockedQ <= 1'b0;
    else if (wrCyc && hitLock) lockedQ <= (pwdata != DATA_W'(UNLOCK_KEY));
  end

  assign misOut = risQ && enQ;

  always_comb begin
    prdata = '0;
    unique case (1'b1)
      hitStart: prdata = startQ;
      hitCount: prdata = cntQ;
      hitCtrl:  prdata = DATA_W'(enQ);
      hitRaw:   prdata = DATA_W'(risQ);
      hitMask:  prdata = DATA_W'(misOut);
      hitLock:  prdata = DATA_W'(lockedQ);
      default:  prdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              tickEn,
  output logic              irqOut
);
  wdogStrobe_t       strobe;
  logic [DATA_W-1:0] startQ;
  logic [DATA_W-1:0] cntQ;
  logic              risQ;
  logic              enQ;
  logic              lockedQ;

  assign pready = 1'b1;

  wdog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .startQ(startQ), .cntQ(cntQ), .risQ(risQ),
    .strobe(strobe), .prdata(prdata), .enQ(enQ), .lockedQ(lockedQ),
    .misOut(irqOut)
  );

  wdog_datapath #(.CNT_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(pwdata), .tickEn(tickEn),
    .startQ(startQ), .cntQ(cntQ), .risQ(risQ)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              pready,
  input logic              tickEn,
  input logic [DATA_W-1:0] startQ,
  input logic [DATA_W-1:0] cntQ,
  input logic              risQ,
  input logic              enQ,
  input logic              lockedQ
);
  logic anyWr;
  logic clrOpen;

  assign anyWr   = psel && penable && pwrite;
  assign clrOpen = anyWr && !lockedQ && (paddr == ADDR_W'(OFF_CLEAR));

  assert_zero_wait_R2: assert property (@(posedge clk) disable iff (!rstN) pready);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && tickEn && cntQ != '0 && !anyWr) |=> (cntQ == $past(cntQ) - DATA_W'(1)));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(enQ && tickEn) && !anyWr) |=> $stable(cntQ));

  assert_flag_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && tickEn && cntQ == DATA_W'(1) && !anyWr) |=> risQ);

  assert_zero_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && tickEn && cntQ == '0 && !anyWr) |=> (cntQ == $past(startQ)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (risQ && !clrOpen) |=> risQ);

  assert_clear_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrOpen |=> (!risQ && cntQ == $past(startQ)));

  assert_locked_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && anyWr && paddr == ADDR_W'(OFF_START)) |=> $stable(startQ));
endmodule

bind tick_watchdog wdog_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pready(pready), .tickEn(tickEn), .startQ(startQ),
  .cntQ(cntQ), .risQ(risQ), .enQ(enQ), .lockedQ(lockedQ)
);

// File: tb/tick_watchdog_test.sv
`timescale 1ns/1ps
module tick_watchdog_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        tickEn = 1'b0;
  logic        irqOut;

  int vecCount = 0;
  int badCount = 0;
  bit finished = 0;

  localparam logic [11:0] A_START = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008,
                          A_CLEAR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00;

  always #2.5 clk = ~clk;

  tick_watchdog uut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .tickEn(tickEn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s: got 0x%08h, expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic expectReg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apbRead(a, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    expectReg("R1 raw flag", A_RAW, 0);
    expectReg("R1 count", A_COUNT, 0);
    expectReg("R1 start", A_START, 0);
    expectReg("R1 control", A_CTRL, 0);
    expectReg("R1 lock", A_LOCK, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
    check("R2 pready", {31'b0, pready}, 1);
  endtask

  task automatic testCountdown();
    apbWrite(A_CTRL, 1);
    apbWrite(A_START, 1000);
    expectReg("R3 load copies", A_COUNT, 1000);
    ticks(500, 0);
    expectReg("R4 half way", A_COUNT, 500);
    expectReg("R4 no flag yet", A_RAW, 0);
    repeat (20) @(negedge clk);
    expectReg("R4 idle hold", A_COUNT, 500);
    ticks(499, 1);
    expectReg("R4 at one", A_COUNT, 1);
    expectReg("R5 flag before zero", A_RAW, 0);
    ticks(1, 0);
    expectReg("R5 count zero", A_COUNT, 0);
    expectReg("R5 flag set", A_RAW, 1);
    expectReg("R8 masked set", A_MASK, 1);
    check("R8 irq high", {31'b0, irqOut}, 1);
    repeat (5) @(negedge clk);
    expectReg("R6 zero held", A_COUNT, 0);
    ticks(1, 0);
    expectReg("R6 reloaded", A_COUNT, 1000);
    expectReg("R6 flag kept", A_RAW, 1);
    ticks(500, 0);
    expectReg("R6 continues", A_COUNT, 500);
    apbWrite(A_CLEAR, 32'hDEAD_BEEF);
    expectReg("R7 reload", A_COUNT, 1000);
    expectReg("R7 flag cleared", A_RAW, 0);
    check("R7 irq low", {31'b0, irqOut}, 0);
  endtask

  task automatic testRate();
    apbWrite(A_START, 20);
    ticks(10, 3);
    expectReg("R10 slow ticks", A_COUNT, 10);
    ticks(9, 0);
    expectReg("R10 fast ticks", A_COUNT, 1);
    ticks(1, 7);
    expectReg("R10 reached zero", A_COUNT, 0);
    expectReg("R10 flag", A_RAW, 1);
  endtask

  task automatic testDisable();
    apbWrite(A_CTRL, 0);
    expectReg("R8 masked off", A_MASK, 0);
    expectReg("R8 raw kept", A_RAW, 1);
    check("R8 irq off", {31'b0, irqOut}, 0);
    ticks(5, 0);
    expectReg("R4 disabled hold", A_COUNT, 0);
  endtask

  task automatic testLock();
    apbWrite(A_LOCK, 0);
    expectReg("R9 locked", A_LOCK, 1);
    apbWrite(A_START, 77);
    expectReg("R9 start ignored", A_START, 20);
    expectReg("R9 count untouched", A_COUNT, 0);
    apbWrite(A_CLEAR, 0);
    expectReg("R9 clear ignored", A_RAW, 1);
    apbWrite(A_CTRL, 1);
    expectReg("R9 ctrl ignored", A_CTRL, 0);
    apbWrite(A_LOCK, 32'h1ACC_E551);
    expectReg("R9 unlocked", A_LOCK, 0);
    apbWrite(A_START, 77);
    expectReg("R9 start after unlock", A_COUNT, 77);
  endtask

  task automatic testUndefined();
    apbWrite(12'h020, 32'hFFFF_FFFF);
    expectReg("R2 undefined read", 12'h020, 0);
    expectReg("R2 clear reads zero", A_CLEAR, 0);
    expectReg("R2 start unaffected", A_START, 77);
    expectReg("R2 ctrl unaffected", A_CTRL, 0);
    check("R2 pready", {31'b0, pready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCountdown();
    testRate();
    testDisable();
    testLock();
    testUndefined();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      vecCount++;
      badCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end
endmodule